// File: doc/BRIEF.md
# Display Identification Byte Transmitter

This block delivers display identification bytes to a host over the slow, vsync-clocked serial path used before a two-wire bus session begins. Software fills an eight-byte FIFO through a simple write port. On every rising edge of vsync the block moves one bit onto its serial data output. Each byte becomes a nine-bit packet: eight data bits, most significant first, then a separator bit of value 1. A selectable low-water mark raises a flag and a one-cycle interrupt pulse so that software knows when to refill. A full flag tells software to stop writing.

The block also tracks which of the two signalling modes is active. A falling edge on the host clock line moves it into the two-wire mode. While that mode is active the serial output rests high and the FIFO is left untouched. If the host clock line stays high for a programmable number of vsync edges (128 by default), the block drops back to the vsync-clocked mode. The exception is an input that reports a valid bus access: once such an access has been seen in two-wire mode, the block stays there. Software can clear the mode flag and that lock at any time.

Top module: `ddc_id_tx`

## Requirements
- R1: After reset the mode flag is 0 (vsync-clocked mode), the serial output is 1, the FIFO is empty, the low flag is 1, the full flag is 0 and the interrupt is 0.
- R2: In vsync-clocked mode each byte is sent as nine bits, one per rising vsync edge: bit 7 down to bit 0, then a 1. The output changes in the clock cycle that follows the cycle in which vsync is first sampled high.
- R3: If the FIFO is empty when a packet would start, the output stays 1 on that vsync edge. The next packet begins on the first vsync edge after a byte has been written.
- R4: The low flag is 1 exactly when the FIFO holds fewer than low_sel+2 bytes (low_sel 0..3 gives thresholds 2, 3, 4 and 5).
- R5: The interrupt is a single-cycle pulse one clock after the low flag rises. It does not pulse while the low flag stays high.
- R6: The full flag is 1 when eight bytes are held. A write while the FIFO is full is dropped, and the bytes already held come out unchanged.
- R7: A falling edge on the host clock line in vsync-clocked mode sets the mode flag one cycle later. While the flag is set, the output is 1 and no byte is taken from the FIFO.
- R8: In two-wire mode, the TIMEOUT-th consecutive rising vsync edge with the host clock line high clears the mode flag. Any cycle with the clock line low restarts that count.
- R9: A valid-access pulse while in two-wire mode locks the mode, so that the vsync timeout no longer clears it.
- R10: A software clear pulse clears the mode flag and the lock one cycle later.
- R11: The busy output equals the inverse of the host clock line, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Byte to enqueue |
| low_sel | input | 2 | Low-water select, threshold = low_sel + 2 |
| vsync | input | 1 | Bit clock in vsync-clocked mode |
| host_scl | input | 1 | Host serial clock line level |
| valid_access | input | 1 | Pulse: a valid two-wire access was decoded |
| ddc2_clr | input | 1 | Pulse: software clear of the mode flag |
| sda_out | output | 1 | Serial data toward the host |
| fifo_low | output | 1 | FIFO below the selected low-water mark |
| fifo_full | output | 1 | FIFO holds eight bytes |
| fifo_low_irq | output | 1 | One-cycle pulse when the low flag rises |
| ddc2_mode | output | 1 | 1 while two-wire mode is active |
| scl_busy | output | 1 | Host clock line is being held low |

## Verification
The assertions assume that vsync and the host clock line are already synchronous to clk, and that every vsync high and low phase lasts at least one clock, so that each edge is seen exactly once. They also assume that the host clock line is high whenever a clear or a valid-access pulse is used to steer the mode. The stimulus changes every input on the falling clock edge. It drives vsync as one cycle high followed by two cycles low, and it keeps the host clock line high except for deliberate single-cycle low pulses, so that all of these conditions hold.

// File: rtl/ddc_id_pkg.sv
package ddc_id_pkg;

   localparam int unsigned LOW_BASE = 2;

   typedef enum logic {
      MODE_VSYNC = 1'b0,
      MODE_TWO_WIRE = 1'b1
   } ddc_mode_e;

   function automatic int unsigned low_threshold(input logic [1:0] sel);
      return int'(sel) + LOW_BASE;
   endfunction

endpackage

// File: rtl/id_fifo.sv
module id_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic [CW-1:0] count
);

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("id_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          wr_ok, rd_ok;

   assign wr_ok   = wr_en && (count != CW'(DEPTH));
   assign rd_ok   = rd_en && (count != '0);
   assign rd_data = mem[rp];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (wr_ok) wp <= wp + 1'b1;
         if (rd_ok) rp <= rp + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/id_serializer.sv
module id_serializer #(
   parameter int unsigned W = 8,
   localparam int unsigned BW = $clog2(W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_tick,
   input  logic         hold,
   input  logic         avail,
   input  logic [W-1:0] head,
   output logic         take,
   output logic         sda
);

   logic [W-1:0]  sh;
   logic [BW-1:0] left;

   assign take = bit_tick && !hold && (left == '0) && avail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sda  <= 1'b1;
         sh   <= '1;
         left <= '0;
      end else if (hold) begin
         sda  <= 1'b1;
         left <= '0;
      end else if (bit_tick) begin
         if (left == '0) begin
            if (avail) begin
               sda  <= head[W-1];
               sh   <= {head[W-2:0], 1'b1};
               left <= BW'(W);
            end else begin
               sda <= 1'b1;
            end
         end else begin
            sda  <= sh[W-1];
            sh   <= {sh[W-2:0], 1'b1};
            left <= left - 1'b1;
         end
      end
   end

endmodule

// File: rtl/ddc_mode_ctl.sv
module ddc_mode_ctl #(
   parameter int unsigned TIMEOUT = 128,
   localparam int unsigned TW     = $clog2(TIMEOUT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_fall,
   input  logic scl_high,
   input  logic bit_tick,
   input  logic valid_access,
   input  logic clr,
   output logic two_wire,
   output logic locked
);

   logic [TW-1:0] tcnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         two_wire <= ddc_id_pkg::MODE_VSYNC;
         locked   <= 1'b0;
         tcnt     <= '0;
      end else if (!two_wire) begin
         locked <= 1'b0;
         tcnt   <= '0;
         if (scl_fall) two_wire <= ddc_id_pkg::MODE_TWO_WIRE;
      end else begin
         if (valid_access) locked <= 1'b1;
         if (!scl_high) begin
            tcnt <= '0;
         end else if (bit_tick) begin
            if (tcnt == TW'(TIMEOUT - 1)) begin
               tcnt <= '0;
               if (!locked && !valid_access) two_wire <= ddc_id_pkg::MODE_VSYNC;
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ddc_id_tx.sv
module ddc_id_tx #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned TIMEOUT     = 128,
   parameter int unsigned SYNC_STAGES = 0,
   localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [1:0]        low_sel,
   input  logic              vsync,
   input  logic              host_scl,
   input  logic              valid_access,
   input  logic              ddc2_clr,
   output logic              sda_out,
   output logic              fifo_low,
   output logic              fifo_full,
   output logic              fifo_low_irq,
   output logic              ddc2_mode,
   output logic              scl_busy
);

   if (DEPTH <= 5) begin : g_bad_depth
      $error("ddc_id_tx: DEPTH must exceed the largest low-water threshold");
   end
   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("ddc_id_tx: TIMEOUT must be at least 2");
   end
   if (BYTE_W < 2) begin : g_bad_width
      $error("ddc_id_tx: BYTE_W must be at least 2");
   end

   logic vs_s, scl_s;

   if (SYNC_STAGES == 0) begin : g_direct
      assign vs_s  = vsync;
      assign scl_s = host_scl;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] vs_r, scl_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vs_r  <= '0;
            scl_r <= '1;
         end else begin
            vs_r  <= (vs_r << 1) | SYNC_STAGES'(vsync);
            scl_r <= (scl_r << 1) | SYNC_STAGES'(host_scl);
         end
      end
      assign vs_s  = vs_r[SYNC_STAGES-1];
      assign scl_s = scl_r[SYNC_STAGES-1];
   end

   logic vs_q, scl_q, low_q;
   logic vs_rise, scl_fall;
   logic fifo_take, ddc2_locked;
   logic [BYTE_W-1:0] head;
   logic [CW-1:0]     count;
   logic [CW:0]       thresh;

   assign vs_rise  = vs_s && !vs_q;
   assign scl_fall = scl_q && !scl_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vs_q         <= 1'b0;
         scl_q        <= 1'b1;
         low_q        <= 1'b1;
         fifo_low_irq <= 1'b0;
         scl_busy     <= 1'b0;
      end else begin
         vs_q         <= vs_s;
         scl_q        <= scl_s;
         low_q        <= fifo_low;
         fifo_low_irq <= fifo_low && !low_q;
         scl_busy     <= !scl_s;
      end
   end

   assign thresh    = (CW+1)'(ddc_id_pkg::low_threshold(low_sel));
   assign fifo_low  = {1'b0, count} < thresh;
   assign fifo_full = count == CW'(DEPTH);

   id_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (fifo_take),
      .rd_data (head),
      .count   (count)
   );

   id_serializer #(.W(BYTE_W)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (vs_rise),
      .hold     (ddc2_mode),
      .avail    (count != '0),
      .head     (head),
      .take     (fifo_take),
      .sda      (sda_out)
   );

   ddc_mode_ctl #(.TIMEOUT(TIMEOUT)) u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_fall     (scl_fall),
      .scl_high     (scl_s),
      .bit_tick     (vs_rise),
      .valid_access (valid_access),
      .clr          (ddc2_clr),
      .two_wire     (ddc2_mode),
      .locked       (ddc2_locked)
   );

endmodule

// File: rtl/ddc_id_tx_chk.sv
module ddc_id_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic scl_s,
   input logic scl_q,
   input logic ddc2_clr,
   input logic fifo_take,
   input logic ddc2_locked,
   input logic sda_out,
   input logic fifo_low,
   input logic fifo_full,
   input logic fifo_low_irq,
   input logic ddc2_mode
);

   assert_full_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full && wr_en && !fifo_take |=> fifo_full);

   assert_low_full_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_low));

   assert_irq_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_low_irq |=> !fifo_low_irq);

   assert_two_wire_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ddc2_mode |=> sda_out);

   assert_two_wire_no_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ddc2_mode |-> !fifo_take);

   assert_scl_fall_enters_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ddc2_mode && scl_q && !scl_s && !ddc2_clr |=> ddc2_mode);

   assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ddc2_locked && !ddc2_clr |=> ddc2_mode);

   assert_clear_exits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ddc2_clr |=> !ddc2_mode && !ddc2_locked);

endmodule

bind ddc_id_tx ddc_id_tx_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .scl_s        (scl_s),
   .scl_q        (scl_q),
   .ddc2_clr     (ddc2_clr),
   .fifo_take    (fifo_take),
   .ddc2_locked  (ddc2_locked),
   .sda_out      (sda_out),
   .fifo_low     (fifo_low),
   .fifo_full    (fifo_full),
   .fifo_low_irq (fifo_low_irq),
   .ddc2_mode    (ddc2_mode)
);

// File: tb/ddc_id_tx_tb_top.sv
module ddc_id_tx_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int TIMEOUT    = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [1:0] low_sel = 2'd0;
   logic       vsync = 1'b0;
   logic       host_scl = 1'b1;
   logic       valid_access = 1'b0;
   logic       ddc2_clr = 1'b0;
   logic       sda_out, fifo_low, fifo_full, fifo_low_irq, ddc2_mode, scl_busy;

   int checks = 0;
   int failures = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   logic [7:0] mq[$];
   int         m_left = 0;
   logic [7:0] m_sh = '1;
   logic       m_sda = 1'b1;
   bit         m_two = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (rst_n && fifo_low_irq) irq_seen++;

   ddc_id_tx dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .low_sel(low_sel), .vsync(vsync), .host_scl(host_scl),
      .valid_access(valid_access), .ddc2_clr(ddc2_clr),
      .sda_out(sda_out), .fifo_low(fifo_low), .fifo_full(fifo_full),
      .fifo_low_irq(fifo_low_irq), .ddc2_mode(ddc2_mode), .scl_busy(scl_busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_low();
      return mq.size() < (int'(low_sel) + 2);
   endfunction

   function automatic bit exp_full();
      return mq.size() == DEPTH;
   endfunction

   task automatic model_tick();
      if (m_two) begin
         m_sda = 1'b1;
         m_left = 0;
      end else if (m_left == 0) begin
         if (mq.size() != 0) begin
            logic [7:0] b;
            b = mq.pop_front();
            m_sda = b[7];
            m_sh = {b[6:0], 1'b1};
            m_left = 8;
         end else begin
            m_sda = 1'b1;
         end
      end else begin
         m_sda = m_sh[7];
         m_sh = {m_sh[6:0], 1'b1};
         m_left--;
      end
   endtask

   task automatic check_flags(input string req);
      check(fifo_low == exp_low(), req, fifo_low, exp_low());
      check(fifo_full == exp_full(), req, fifo_full, exp_full());
   endtask

   task automatic wr(input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
      if (mq.size() < DEPTH) mq.push_back(b);
   endtask

   task automatic vs_pulse(input string req);
      @(negedge clk);
      vsync = 1'b1;
      @(negedge clk);
      model_tick();
      check(sda_out == m_sda, req, sda_out, m_sda);
      vsync = 1'b0;
      @(negedge clk);
   endtask

   task automatic scl_dip();
      @(negedge clk);
      host_scl = 1'b0;
      @(negedge clk);
      check(scl_busy == 1'b1, "R11", scl_busy, 1);
      host_scl = 1'b1;
      @(negedge clk);
      check(scl_busy == 1'b0, "R11", scl_busy, 0);
   endtask

   task automatic drain();
      while (mq.size() != 0 || m_left != 0) vs_pulse("R2");
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240613));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(ddc2_mode == 1'b0, "R1", ddc2_mode, 0);
      check(sda_out == 1'b1, "R1", sda_out, 1);
      check(fifo_low == 1'b1, "R1", fifo_low, 1);
      check(fifo_full == 1'b0, "R1", fifo_full, 0);
      check(fifo_low_irq == 1'b0, "R1", fifo_low_irq, 0);

      // R3 empty FIFO keeps output high
      vs_pulse("R3");
      vs_pulse("R3");

      // R2 two packets, MSB first with separator
      wr(8'hA5);
      wr(8'h3C);
      check_flags("R4");
      repeat (18) vs_pulse("R2");
      vs_pulse("R3");

      // R6 fill, overfill, drain intact
      for (int i = 0; i < DEPTH; i++) wr(8'(8'h11 * (i + 1)));
      check(fifo_full == 1'b1, "R6", fifo_full, 1);
      wr(8'hEE);
      check(fifo_full == 1'b1, "R6", fifo_full, 1);
      drain();
      check(fifo_low == 1'b1, "R6", fifo_low, 1);

      // R4 thresholds for each select value
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         low_sel = 2'(s);
         for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            check_flags("R4");
            wr(8'(n + 8'h40));
         end
         drain();
      end

      // R5 interrupt pulse on low rising
      @(negedge clk);
      low_sel = 2'd0;
      wr(8'h81);
      wr(8'h7E);
      check(fifo_low == 1'b0, "R5", fifo_low, 0);
      irq_seen = 0;
      vs_pulse("R5");
      repeat (4) @(negedge clk);
      check(irq_seen == 1, "R5", irq_seen, 1);
      drain();
      repeat (4) @(negedge clk);
      check(irq_seen == 1, "R5", irq_seen, 1);

      // Random mix
      for (int it = 0; it < 400; it++) begin
         int unsigned r;
         r = $urandom % 8;
         if (r < 3) wr(8'($urandom));
         else if (r == 3) begin
            @(negedge clk);
            low_sel = 2'($urandom);
         end else vs_pulse("R2");
         @(negedge clk);
         check_flags("R4");
      end
      drain();

      // R7 enter two-wire mode, FIFO untouched
      wr(8'hC3);
      scl_dip();
      check(ddc2_mode == 1'b1, "R7", ddc2_mode, 1);
      m_two = 1'b1;
      repeat (TIMEOUT - 1) vs_pulse("R7");
      check(ddc2_mode == 1'b1, "R8", ddc2_mode, 1);
      check(fifo_low == 1'b1 && fifo_full == 1'b0, "R7", fifo_low, 1);
      vs_pulse("R7");
      m_two = 1'b0;
      check(ddc2_mode == 1'b0, "R8", ddc2_mode, 0);

      // R8 low clock line restarts the count
      scl_dip();
      m_two = 1'b1;
      check(ddc2_mode == 1'b1, "R7", ddc2_mode, 1);
      repeat (100) vs_pulse("R7");
      scl_dip();
      repeat (TIMEOUT - 1) vs_pulse("R8");
      check(ddc2_mode == 1'b1, "R8", ddc2_mode, 1);
      vs_pulse("R8");
      m_two = 1'b0;
      check(ddc2_mode == 1'b0, "R8", ddc2_mode, 0);
      repeat (9) vs_pulse("R7");

      // R9 valid access locks the mode
      scl_dip();
      m_two = 1'b1;
      @(negedge clk);
      valid_access = 1'b1;
      @(negedge clk);
      valid_access = 1'b0;
      repeat (TIMEOUT + 12) vs_pulse("R9");
      check(ddc2_mode == 1'b1, "R9", ddc2_mode, 1);

      // R10 software clear removes flag and lock
      @(negedge clk);
      ddc2_clr = 1'b1;
      @(negedge clk);
      ddc2_clr = 1'b0;
      m_two = 1'b0;
      check(ddc2_mode == 1'b0, "R10", ddc2_mode, 0);
      scl_dip();
      m_two = 1'b1;
      repeat (TIMEOUT) vs_pulse("R10");
      m_two = 1'b0;
      check(ddc2_mode == 1'b0, "R10", ddc2_mode, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule